// File: doc/BRIEF.md
# Fault Input Capture Register

This block samples four asynchronous fault inputs and reports them through one 8-bit read-only status byte. For every input the byte carries two bits: the current level of the input after synchronization, and a sticky event flag that is set when the input rises. Once set, a flag stays set until software clears it. To clear it, software writes a one to the matching bit of a separate write-only acknowledge register.

The flags are also driven out as a per-input vector every cycle. Downstream logic, such as an interrupt request or a drive-disable path, can use them without a bus read. Access is through a simple register bus. It has an address, read and write strobes, and 8-bit write and read data. The read data is combinational from the address and read strobe.

Top module: `fault_capture`

## Requirements
- R1: A read at offset 0 returns the status byte. For input k (k = 1..4), bit 2k-1 holds its level and bit 2k-2 holds its event flag. From the top bit down, the order is level4, flag4, level3, flag3, level2, flag2, level1, flag1.
- R2: A level bit reads 1 when its input is high and 0 when it is low. It is valid after the second rising clock edge following an input change, and reset does not affect it.
- R3: A rising input sets its flag at the third rising clock edge after the change. That is two cycles after the first edge that samples the change. A falling input or a steady level never sets a flag.
- R4: A set flag stays set until it is acknowledged, even after its input returns low.
- R5: A write at offset 1 clears the flag of input k when write-data bit 2k-2 is 1 (bits 6, 4, 2, 0 for inputs 4, 3, 2, 1). A 0 in that bit leaves the flag as it is, and the odd write-data bits are ignored.
- R6: If a rising edge and an acknowledge for the same input fall in the same cycle, the flag ends up set.
- R7: A write at offset 0 changes no flag.
- R8: A synchronous reset clears all flags.
- R9: Reads at offset 1 and at every offset other than 0 return zero. With the read strobe low, the read data is zero.
- R10: The flag output vector equals the event flags every cycle. Bit k-1 of the vector carries the flag of input k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fault_pin | input | 4 | Asynchronous fault inputs; bit k-1 is input k |
| bus_addr | input | 4 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| fault_flag | output | 4 | Registered event flags; bit k-1 is input k |

## Verification
An input change made between clock edges reaches the level bits two rising edges later and the flag one edge after that. The bench drives every input change at a falling edge. It reads the status byte after two edges, expecting the new levels with the old flags, and again after the third edge, expecting the updated flags. Acknowledge writes and writes at offset 0 take effect on the single edge that ends the write, so the bench checks the flags at the following falling edge. The same-cycle case is set up so that the acknowledge is active exactly across the third edge after an input rises.

// File: rtl/fault_capture_pkg.sv
package fault_capture_pkg;
    localparam int unsigned STATUS_OFS = 0;
    localparam int unsigned ACK_OFS    = 1;

    typedef enum logic [1:0] {
        SEL_STATUS,
        SEL_ACK,
        SEL_NONE
    } reg_sel_e;
endpackage

// File: rtl/fault_sync.sv
module fault_sync #(
    parameter int NUM_PINS = 4
) (
    input  logic                clk_i,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] level_o,
    output logic [NUM_PINS-1:0] rise_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] meta;
        logic [NUM_PINS-1:0] stable;
        logic [NUM_PINS-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = pin_i;
        sync_d.stable = sync_q.meta;
        sync_d.prev   = sync_q.stable;
    end

    // level bits carry no reset: they always track the inputs
    always_ff @(posedge clk_i) begin
        sync_q <= sync_d;
    end

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        assign level_o[k] = sync_q.stable[k];
        assign rise_o[k]  = sync_q.stable[k] & ~sync_q.prev[k];
    end
endmodule

// File: rtl/fault_flags.sv
module fault_flags #(
    parameter int NUM_PINS = 4
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [NUM_PINS-1:0] rise_i,
    input  logic [NUM_PINS-1:0] ack_i,
    output logic [NUM_PINS-1:0] flags_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] flag;
    } flag_t;

    flag_t flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        // set wins over a simultaneous acknowledge
        flag_d.flag = (flag_q.flag & ~ack_i) | rise_i;
        if (rst_i) begin
            flag_d.flag = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        flag_q <= flag_d;
    end

    assign flags_o = flag_q.flag;
endmodule

// File: rtl/fault_regif.sv
module fault_regif
    import fault_capture_pkg::*;
#(
    parameter  int NUM_PINS = 4,
    parameter  int ADDR_W   = 4,
    localparam int DATA_W   = 2 * NUM_PINS
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                rd_i,
    input  logic                wr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [NUM_PINS-1:0] level_i,
    input  logic [NUM_PINS-1:0] flags_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [NUM_PINS-1:0] ack_o
);
    reg_sel_e            sel;
    logic [DATA_W-1:0]   status_w;
    logic [NUM_PINS-1:0] unused_wodd;

    always_comb begin
        if (addr_i == ADDR_W'(STATUS_OFS)) begin
            sel = SEL_STATUS;
        end else if (addr_i == ADDR_W'(ACK_OFS)) begin
            sel = SEL_ACK;
        end else begin
            sel = SEL_NONE;
        end
    end

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_bits
        assign status_w[2*k+1] = level_i[k];
        assign status_w[2*k]   = flags_i[k];
        assign ack_o[k]        = wr_i && (sel == SEL_ACK) && wdata_i[2*k];
        assign unused_wodd[k]  = wdata_i[2*k+1];
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i && (sel == SEL_STATUS)) begin
            rdata_o = status_w;
        end
    end
endmodule

// File: rtl/fault_capture.sv
module fault_capture #(
    parameter  int NUM_PINS = 4,
    parameter  int ADDR_W   = 4,
    localparam int DATA_W   = 2 * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] fault_pin,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_PINS-1:0] fault_flag
);
    logic [NUM_PINS-1:0] level_w;
    logic [NUM_PINS-1:0] rise_w;
    logic [NUM_PINS-1:0] ack_w;
    logic [NUM_PINS-1:0] flag_w;

    fault_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk_i   (clk),
        .pin_i   (fault_pin),
        .level_o (level_w),
        .rise_o  (rise_w)
    );

    fault_flags #(.NUM_PINS(NUM_PINS)) u_flags (
        .clk_i   (clk),
        .rst_i   (rst),
        .rise_i  (rise_w),
        .ack_i   (ack_w),
        .flags_o (flag_w)
    );

    fault_regif #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regif (
        .addr_i  (bus_addr),
        .rd_i    (bus_rd),
        .wr_i    (bus_wr),
        .wdata_i (bus_wdata),
        .level_i (level_w),
        .flags_i (flag_w),
        .rdata_o (bus_rdata),
        .ack_o   (ack_w)
    );

    assign fault_flag = flag_w;
endmodule

// File: rtl/fault_capture_chk.sv
module fault_capture_chk
    import fault_capture_pkg::*;
#(
    parameter  int NUM_PINS = 4,
    parameter  int ADDR_W   = 4,
    localparam int DATA_W   = 2 * NUM_PINS
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_rd,
    input logic                bus_wr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [NUM_PINS-1:0] fault_flag,
    input logic [NUM_PINS-1:0] rise_i
);
    logic at_status;
    logic at_ack;
    assign at_status = (bus_addr == ADDR_W'(STATUS_OFS));
    assign at_ack    = (bus_addr == ADDR_W'(ACK_OFS));

    p_reset_clears_r8: assert property (@(posedge clk) rst |=> (fault_flag == '0));

    p_rdata_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd || !at_status) |-> (bus_rdata == '0));

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        logic ack_k;
        assign ack_k = bus_wr && at_ack && bus_wdata[2*k];

        // R3 and R6: an edge sets the flag regardless of an acknowledge
        p_edge_sets_r3: assert property (@(posedge clk) disable iff (rst)
            rise_i[k] |=> fault_flag[k]);

        p_no_spurious_r3: assert property (@(posedge clk) disable iff (rst)
            (!fault_flag[k] && !rise_i[k]) |=> !fault_flag[k]);

        p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
            (fault_flag[k] && !ack_k) |=> fault_flag[k]);

        p_ack_clears_r5: assert property (@(posedge clk) disable iff (rst)
            (ack_k && !rise_i[k]) |=> !fault_flag[k]);

        p_status_ro_r7: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && at_status && !rise_i[k]) |=> $stable(fault_flag[k]));

        p_flag_bit_r10: assert property (@(posedge clk) disable iff (rst)
            (bus_rd && at_status) |-> (bus_rdata[2*k] == fault_flag[k]));
    end
endmodule

bind fault_capture fault_capture_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .fault_flag (fault_flag),
    .rise_i     (rise_w)
);

// File: tb/fault_capture_bench.sv
module fault_capture_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] fault_pin = 4'h0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] fault_flag;

    int errors = 0;
    int checks = 0;
    logic [3:0] m_lvl = 4'h0;
    logic [3:0] m_flg = 4'h0;

    fault_capture u_fault_capture (
        .clk(clk), .rst(rst), .fault_pin(fault_pin), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .fault_flag(fault_flag)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] pack(input logic [3:0] lv, input logic [3:0] fl);
        logic [7:0] s = 8'h00;
        for (int k = 0; k < 4; k++) begin
            s[2*k+1] = lv[k];
            s[2*k]   = fl[k];
        end
        return s;
    endfunction

    function automatic logic [7:0] spread(input logic [3:0] m);
        logic [7:0] s = 8'h00;
        for (int k = 0; k < 4; k++) s[2*k] = m[k];
        return s;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic check_status(input string req);
        logic [7:0] d;
        rd_reg(4'd0, d);
        check(req, d, pack(m_lvl, m_flg));
        check("R10", {4'h0, fault_flag}, {4'h0, m_flg});
    endtask

    // drive new input levels and follow the latency of R2 and R3
    task automatic apply(input logic [3:0] p);
        logic [3:0] rising = p & ~m_lvl;
        fault_pin = p;
        tick(2);
        m_lvl = p;
        check_status("R2");
        tick(1);
        m_flg = m_flg | rising;
        check_status("R3");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        @(negedge clk);
        tick(4);
        rst = 1'b0;
        tick(1);
        check_status("R8");

        // R1 R2 R3 R4: sweep every level pattern and its complement
        for (int p = 0; p < 16; p++) begin
            apply(4'(p));
            apply(~4'(p));
        end
        check_status("R4");
        wr_reg(4'd1, 8'h55);
        m_flg = 4'h0;
        check_status("R5");

        // R5: every acknowledge mask, odd bits set and ignored
        for (int m = 0; m < 16; m++) begin
            apply(4'h0);
            apply(4'hF);
            wr_reg(4'd1, spread(4'(m)) | 8'hAA);
            m_flg = m_flg & ~4'(m);
            check_status("R5");
            // R7: write at status offset leaves flags
            wr_reg(4'd0, 8'hFF);
            check_status("R7");
            // R9: acknowledge and unused offsets read zero
            for (int a = 1; a < 16; a++) begin
                rd_reg(4'(a), d);
                check("R9", d, 8'h00);
            end
            bus_addr = 4'd0;
            #1;
            check("R9", bus_rdata, 8'h00);
        end

        // R6: edge and acknowledge on the same clock edge
        wr_reg(4'd1, 8'h55);
        m_flg = 4'h0;
        apply(4'h0);
        fault_pin = 4'h1;
        tick(2);
        m_lvl = 4'h1;
        bus_addr  = 4'd1;
        bus_wdata = 8'h55;
        bus_wr    = 1'b1;
        tick(1);
        bus_wr = 1'b0;
        m_flg = 4'h1;
        check_status("R6");

        // R8 with flags set and R2 level unaffected by reset
        apply(4'hF);
        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        m_flg = 4'h0;
        check_status("R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule